// File: doc/BRIEF.md
# Sixteen-Operation ALU with Status Flags

This block is the arithmetic-logic unit of a small register machine. It takes two operands and a 4-bit operation code. In the same cycle it returns a result word, a write-back enable for the destination register, and four status flags: Zero, Negative, Carry and Overflow.

Every add-type and subtract-type operation runs through one shared adder. A decoder feeds that adder with steered operands and a carry-in. The other operations (logic, single-bit shifts, pass-through and the two constants) come from a separate bitwise unit. An output multiplexer picks one of the two, chosen by the decoded operation class.

A parameter can add a registered flag stage. That stage captures the combinational flags at a clock edge while its load input is high, except when the operation is a no-op. The enclosing machine can then branch on flags from an earlier instruction.

Top module: `alu16_core`

## Requirements
- R1: `result` is computed modulo 2^W for each arithmetic opcode:
  - 0x0 gives src_a+src_b.
  - 0x1 gives src_a-src_b.
  - 0x8 gives src_a+1.
  - 0x9 gives src_a-1.
  - 0xB gives 0-src_a.
- R2: The bitwise opcodes give:
  - 0x2: AND of the operands.
  - 0x3: OR of the operands.
  - 0x4: XOR of the operands.
  - 0x5: bitwise NOT of src_a.
  - 0xC: src_a unchanged.
  
  The single-operand ones ignore src_b.
- R3: Opcode 0xD gives all zeros and 0xE gives all ones, whatever the operands are.
- R4: Shifts fill with zero and put the bit shifted out into C:
  - 0x6 shifts src_a left by one; C takes the old top bit.
  - 0x7 shifts src_a right by one; C takes the old bit 0.
- R5: `flags_now` is packed as {Z,N,C,V} in bits 3..0. Z is 1 exactly when `result` is zero, and N equals the top bit of `result`. This holds for every opcode except 0xF.
- R6: C is the carry out of the top bit for 0x0 and 0x8. For 0x1, 0xA, 0x9 and 0xB, C is the "no borrow" indication, that is, the carry out of x + ~y + 1.
- R7: V is 1 when an add-type or subtract-type operation (0x0, 0x1, 0x8, 0x9, 0xA, 0xB) overflows as a signed two's-complement value.
- R8: Logic, pass-through and constant opcodes (0x2-0x5, 0xC-0xE) drive C=0 and V=0.
- R9: Compare (0xA) produces the same `result` and flags as 0x1 but holds `wr_en` low. `wr_en` is high for every other opcode except 0xF.
- R10: No-op (0xF) drives `result`=0, `flags_now`=0000 and `wr_en`=0.
- R11: `flags_q` resets to 0000. At a rising clock edge it loads `flags_now` when `flag_ld` is high and the opcode is not 0xF. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered flag stage |
| rst_n | input | 1 | Active-low asynchronous reset of the flag stage |
| src_a | input | W | First operand |
| src_b | input | W | Second operand |
| opcode | input | 4 | Operation code |
| flag_ld | input | 1 | Load enable for the registered flags |
| result | output | W | Operation result |
| wr_en | output | 1 | Destination write-back enable |
| flags_now | output | 4 | Combinational flags {Z,N,C,V} |
| flags_q | output | 4 | Registered flags {Z,N,C,V} |

## Verification
The bench builds the block with W=16 and REG_FLAGS=1, so the registered flag stage is present and the load/hold behaviour of `flags_q` can be observed at the ports. With a 16-bit word, the boundary operands 0x0000, 0x7FFF, 0x8000 and 0xFFFF are used directly. They expose:
- carry and no-borrow at wrap-around;
- signed overflow at both ends of the range;
- the shift carries from the end bits.

Each vector also checks the flag register one edge later, which covers the no-op hold. Directed steps then cover the load-disabled hold and a reset in the middle of a run.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_AND  = 4'h2,
        OP_OR   = 4'h3,
        OP_XOR  = 4'h4,
        OP_NOT  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_INC  = 4'h8,
        OP_DEC  = 4'h9,
        OP_CMP  = 4'hA,
        OP_NEG  = 4'hB,
        OP_PASS = 4'hC,
        OP_ZERO = 4'hD,
        OP_ONES = 4'hE,
        OP_NOP  = 4'hF
    } alu_op_e;

    // Which datapath produces the result
    typedef enum logic [1:0] {
        U_SUM   = 2'd0,
        U_BIT   = 2'd1,
        U_SHIFT = 2'd2,
        U_IDLE  = 2'd3
    } unit_e;

    // Steering of the adder's second input
    typedef enum logic [2:0] {
        BS_B    = 3'd0,
        BS_NOTB = 3'd1,
        BS_ZERO = 3'd2,
        BS_ONES = 3'd3,
        BS_NOTA = 3'd4
    } bsel_e;

    typedef struct packed {
        unit_e unit;
        logic  a_zero;   // adder first input forced to zero
        bsel_e bsel;
        logic  cin;
        logic  wr;       // write-back enable
        logic  upd;      // flags meaningful / loadable
    } ctl_t;

    localparam int FLAG_Z = 3;
    localparam int FLAG_N = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
    import alu16_pkg::*;
(
    input  logic [3:0] opcode,
    output ctl_t       ctl
);
    alu_op_e op;
    assign op = alu_op_e'(opcode);

    always_comb begin
        ctl = '{unit: U_BIT, a_zero: 1'b0, bsel: BS_B, cin: 1'b0,
                wr: 1'b1, upd: 1'b1};
        unique case (op)
            OP_ADD:  begin ctl.unit = U_SUM; ctl.bsel = BS_B; end
            OP_SUB:  begin ctl.unit = U_SUM; ctl.bsel = BS_NOTB; ctl.cin = 1'b1; end
            OP_CMP:  begin ctl.unit = U_SUM; ctl.bsel = BS_NOTB; ctl.cin = 1'b1;
                           ctl.wr = 1'b0; end
            OP_INC:  begin ctl.unit = U_SUM; ctl.bsel = BS_ZERO; ctl.cin = 1'b1; end
            OP_DEC:  begin ctl.unit = U_SUM; ctl.bsel = BS_ONES; end
            OP_NEG:  begin ctl.unit = U_SUM; ctl.a_zero = 1'b1; ctl.bsel = BS_NOTA;
                           ctl.cin = 1'b1; end
            OP_SHL, OP_SHR: ctl.unit = U_SHIFT;
            OP_AND, OP_OR, OP_XOR, OP_NOT,
            OP_PASS, OP_ZERO, OP_ONES: ctl.unit = U_BIT;
            OP_NOP:  begin ctl.unit = U_IDLE; ctl.wr = 1'b0; ctl.upd = 1'b0; end
            default: begin ctl.unit = U_IDLE; ctl.wr = 1'b0; ctl.upd = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu16_sum.sv
module alu16_sum #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   opcode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         shc
);
    localparam int MSB = W - 1;
    alu_op_e op;
    assign op = alu_op_e'(opcode);

    always_comb begin
        res = '0;
        shc = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_PASS: res = a;
            OP_ZERO: res = '0;
            OP_ONES: res = '1;
            OP_SHL:  begin res = {a[MSB-1:0], 1'b0}; shc = a[MSB]; end
            OP_SHR:  begin res = {1'b0, a[MSB:1]};   shc = a[0];   end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W         = 16,
    parameter bit REG_FLAGS = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [3:0]   opcode,
    input  logic         flag_ld,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [3:0]   flags_now,
    output logic [3:0]   flags_q
);
    localparam int MSB = W - 1;

    ctl_t         ctl;
    logic [W-1:0] add_a, add_b, sum;
    logic         cout, ovf;
    logic [W-1:0] bit_res;
    logic         shc;

    alu16_decode u_dec (.opcode(opcode), .ctl(ctl));

    always_comb begin
        add_a = ctl.a_zero ? '0 : src_a;
        case (ctl.bsel)
            BS_B:    add_b = src_b;
            BS_NOTB: add_b = ~src_b;
            BS_ZERO: add_b = '0;
            BS_ONES: add_b = '1;
            BS_NOTA: add_b = ~src_a;
            default: add_b = '0;
        endcase
    end

    alu16_sum #(.W(W)) u_sum (
        .a(add_a), .b(add_b), .cin(ctl.cin),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    alu16_bitwise #(.W(W)) u_bit (
        .opcode(opcode), .a(src_a), .b(src_b), .res(bit_res), .shc(shc)
    );

    always_comb begin
        result    = '0;
        flags_now = '0;
        unique case (ctl.unit)
            U_SUM:   begin
                result            = sum;
                flags_now[FLAG_C] = cout;
                flags_now[FLAG_V] = ovf;
            end
            U_SHIFT: begin
                result            = bit_res;
                flags_now[FLAG_C] = shc;
            end
            U_BIT:   result = bit_res;
            U_IDLE:  result = '0;
            default: result = '0;
        endcase
        if (ctl.upd) begin
            flags_now[FLAG_Z] = (result == '0);
            flags_now[FLAG_N] = result[MSB];
        end
        wr_en = ctl.wr;
    end

    generate
        if (REG_FLAGS) begin : g_flag_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flags_q <= '0;
                else if (flag_ld && ctl.upd)
                    flags_q <= flags_now;
            end
        end else begin : g_flag_wire
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst_n, flag_ld};
            assign flags_q   = flags_now;
        end
    endgenerate
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
    parameter int W         = 16,
    parameter bit REG_FLAGS = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   opcode,
    input logic         flag_ld,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic [3:0]   flags_now,
    input logic [3:0]   flags_q
);
    logic is_nop, is_cmp, is_plain;
    assign is_nop   = (opcode == 4'hF);
    assign is_cmp   = (opcode == 4'hA);
    assign is_plain = (opcode inside {4'h2, 4'h3, 4'h4, 4'h5, 4'hC, 4'hD, 4'hE});

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_nop || is_cmp) |-> !wr_en); // R9
    AST_WRITE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_nop || is_cmp) |-> wr_en); // R9
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> (flags_now[3] == (result == '0))); // R5
    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> (flags_now[2] == result[W-1])); // R5
    AST_PLAIN_CV: assert property (@(posedge clk) disable iff (!rst_n)
        is_plain |-> (flags_now[1:0] == 2'b00)); // R8
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |-> (result == '0 && flags_now == 4'b0000)); // R10

    generate
        if (REG_FLAGS) begin : g_reg_chk
            AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_ld || is_nop) |=> $stable(flags_q)); // R11
            AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_ld && !is_nop) |=> (flags_q == $past(flags_now))); // R11
        end
    endgenerate
endmodule

bind alu16_core alu16_core_chk #(.W(W), .REG_FLAGS(REG_FLAGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .flag_ld(flag_ld),
    .result(result), .wr_en(wr_en), .flags_now(flags_now), .flags_q(flags_q)
);

// File: tb/sim_alu16_core.sv
`timescale 1ns/1ps
module sim_alu16_core;
    localparam int W = 16;

    typedef struct packed {
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] r;
        logic [3:0]   f;   // {Z,N,C,V}
        logic         we;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 16'h1234, 16'h1111, 16'h2345, 4'b0000, 1'b1}, // R1 add
        '{4'h0, 16'hFFFF, 16'h0001, 16'h0000, 4'b1010, 1'b1}, // R6 carry
        '{4'h0, 16'h7FFF, 16'h0001, 16'h8000, 4'b0101, 1'b1}, // R7 ovf
        '{4'h1, 16'h0005, 16'h0003, 16'h0002, 4'b0010, 1'b1}, // R6 no borrow
        '{4'h1, 16'h0003, 16'h0005, 16'hFFFE, 4'b0100, 1'b1}, // R6 borrow
        '{4'h1, 16'h8000, 16'h0001, 16'h7FFF, 4'b0011, 1'b1}, // R7 sub ovf
        '{4'h2, 16'hF0F0, 16'h3C3C, 16'h3030, 4'b0000, 1'b1}, // R2 and
        '{4'h3, 16'hF000, 16'h000F, 16'hF00F, 4'b0100, 1'b1}, // R2 or
        '{4'h4, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b1000, 1'b1}, // R2 xor
        '{4'h5, 16'h00FF, 16'h1234, 16'hFF00, 4'b0100, 1'b1}, // R2 not
        '{4'h6, 16'h8001, 16'h0000, 16'h0002, 4'b0010, 1'b1}, // R4 shl
        '{4'h7, 16'h8001, 16'h0000, 16'h4000, 4'b0010, 1'b1}, // R4 shr
        '{4'h7, 16'h0002, 16'hFFFF, 16'h0001, 4'b0000, 1'b1}, // R4 shr c0
        '{4'h8, 16'hFFFF, 16'h0000, 16'h0000, 4'b1010, 1'b1}, // R1 inc wrap
        '{4'h8, 16'h7FFF, 16'h0000, 16'h8000, 4'b0101, 1'b1}, // R7 inc ovf
        '{4'h9, 16'h0000, 16'h0000, 16'hFFFF, 4'b0100, 1'b1}, // R6 dec borrow
        '{4'h9, 16'h8000, 16'h0000, 16'h7FFF, 4'b0011, 1'b1}, // R7 dec ovf
        '{4'hA, 16'h0007, 16'h0007, 16'h0000, 4'b1010, 1'b0}, // R9 cmp
        '{4'hB, 16'h0001, 16'h0000, 16'hFFFF, 4'b0100, 1'b1}, // R1 neg
        '{4'hB, 16'h0000, 16'h0000, 16'h0000, 4'b1010, 1'b1}, // R6 neg zero
        '{4'hB, 16'h8000, 16'h0000, 16'h8000, 4'b0101, 1'b1}, // R7 neg min
        '{4'hC, 16'h8000, 16'hFFFF, 16'h8000, 4'b0100, 1'b1}, // R8 pass
        '{4'hD, 16'h5555, 16'hAAAA, 16'h0000, 4'b1000, 1'b1}, // R3 zero
        '{4'hE, 16'h0000, 16'h0000, 16'hFFFF, 4'b0100, 1'b1}, // R3 ones
        '{4'hF, 16'h1234, 16'h4321, 16'h0000, 4'b0000, 1'b0}  // R10 nop
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_a = '0, src_b = '0;
    logic [3:0]   opcode = 4'hF;
    logic         flag_ld = 1'b0;
    logic [W-1:0] result;
    logic         wr_en;
    logic [3:0]   flags_now, flags_q;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q;

    always #10 clk = ~clk;

    alu16_core #(.W(W), .REG_FLAGS(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .opcode(opcode), .flag_ld(flag_ld), .result(result), .wr_en(wr_en),
        .flags_now(flags_now), .flags_q(flags_q)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic ld);
        @(negedge clk);
        opcode = op; src_a = a; src_b = b; flag_ld = ld;
        #2;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state (R11)
        repeat (2) @(negedge clk);
        check("R11 reset flags_q", 32'(flags_q), 32'h0);
        rst_n = 1'b1;
        exp_q = 4'b0000;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].a, VECS[i].b, 1'b1);
            check($sformatf("R1-table result op %h", VECS[i].op),
                  32'(result), 32'(VECS[i].r));
            check($sformatf("R5 flags op %h", VECS[i].op),
                  32'(flags_now), 32'(VECS[i].f));
            check($sformatf("R9 wr_en op %h", VECS[i].op),
                  32'(wr_en), 32'(VECS[i].we));
            if (VECS[i].op != 4'hF) exp_q = VECS[i].f;
            @(negedge clk);
            check($sformatf("R11 flags_q after op %h", VECS[i].op),
                  32'(flags_q), 32'(exp_q));
        end

        // R11: load disabled keeps flags_q
        drive(4'h0, 16'h0001, 16'h0001, 1'b1);  // 0002 -> flags 0000
        @(negedge clk);
        check("R11 load", 32'(flags_q), 32'h0);
        drive(4'h0, 16'hFFFF, 16'h0001, 1'b0);  // flags 1010, not loaded
        check("R6 carry wrap", 32'(flags_now), 32'hA);
        @(negedge clk);
        check("R11 hold when flag_ld low", 32'(flags_q), 32'h0);

        // R10: no-op with load high keeps flags_q
        drive(4'h1, 16'h0003, 16'h0005, 1'b1);  // flags 0100
        @(negedge clk);
        check("R11 load sub flags", 32'(flags_q), 32'h4);
        drive(4'hF, 16'h0000, 16'h0000, 1'b1);
        check("R10 nop result", 32'(result), 32'h0);
        @(negedge clk);
        check("R10 nop keeps flags_q", 32'(flags_q), 32'h4);

        // R2/R3: single-operand ops ignore src_b
        drive(4'hC, 16'h1357, 16'hFFFF, 1'b0);
        check("R2 pass ignores src_b", 32'(result), 32'h1357);
        drive(4'hE, 16'h1357, 16'h0000, 1'b0);
        check("R3 ones ignores operands", 32'(result), 32'hFFFF);

        // R11: reset mid-run clears flags_q
        drive(4'h0, 16'hFFFF, 16'h0001, 1'b1);
        @(negedge clk);
        check("R11 load before reset", 32'(flags_q), 32'hA);
        rst_n = 1'b0;
        #2;
        check("R11 async reset clears", 32'(flags_q), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule